// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines (a multiple of eight, at most 256) and turns each into a pending flag according to that line's own sense configuration: level sensitive with a chosen active level, single-edge sensitive with a chosen direction, or sensitive to both edges. Every line carries its own enable mask and its own route, which names the target processors as a one-hot field and a pin number on each of them. The block drives a flat vector of processor interrupt pins.

Software reaches the block through a simple synchronous write port and a combinational read port. Masks change through two command addresses that take a line index, so no read-modify-write is needed. A single command address either raises a line as pending (for inter-processor signalling) or acknowledges a latched edge, chosen by bit 31 of the written word. Pending flags and masks can be read back as packed 32-bit words, and the sense and route settings of each line can be read back at their own addresses.

Top module: `shared_irq_ctrl`

## Requirements
- R1: Reading address 0x000 returns NUM_SRC/8-1 in bits [4:0] and zero elsewhere (3 for the default of 32 lines).
- R2: After reset every line is masked, its sense word reads 0x1 (active-high level), its route word reads 0 (pin mapping off) and every pin output is low.
- R3: A write of index k to address 0x001 enables line k on the next cycle and leaves every other mask bit unchanged.
- R4: A write of index k to address 0x002 disables line k on the next cycle and leaves every other mask bit unchanged.
- R5: Sense word at 0x100+k has bit0 = high/rising, bit1 = edge mode, bit2 = both edges; with bit1 clear the pending flag equals the input (bit0 = 1) or its inverse (bit0 = 0), and an acknowledge does not clear it.
- R6: In single-edge mode (bit1 = 1, bit2 = 0) a transition in the direction chosen by bit0 sets the pending flag, which stays set after the input returns.
- R7: In both-edges mode (bits 1 and 2 set) either transition sets the pending flag whatever bit0 holds.
- R8: A write to address 0x003 with bit31 = 1 and index k in bits [7:0] sets line k pending if it is in edge mode; with bit31 = 0 it clears the latched edge of line k.
- R9: Route word at 0x200+k has the processor one-hot field in bits [NUM_CPU-1:0], the pin number from bit 8 and a map enable in bit 15; pin output irqPins[c*NUM_PIN+p] goes high one cycle after some line is pending, unmasked, map-enabled, routed to processor c and pin p, and low once none is.
- R10: Words at 0x010+w and 0x020+w return pending and mask bits of lines 32w to 32w+31.
- R11: Mask and wedge commands whose index is at or above NUM_SRC change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| intIn | input | NUM_SRC | External interrupt lines, synchronous to clk |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 10 | Register address for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| irqPins | output | NUM_CPU*NUM_PIN | Processor interrupt pins, index cpu*NUM_PIN+pin |

## Verification
The sense table walks one line through every level, single-edge and both-edge setting with inputs that should and should not fire, acknowledging between steps; a design that decodes the polarity backwards, honours polarity in both-edge mode or lets an acknowledge clear a level line gives the wrong pending bit. Directed tests aim at mask commands touching neighbours, indices past the last line, a raised line routed to one exact pin, and pins that must stay low with mapping off or the mask cleared; a wrong pin index, a sticky pin or an out-of-range command wrapping onto a real line each shows at the ports.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int DW = 32;
  localparam int AW = 10;

  localparam logic [7:0] SEL_CONFIG  = 8'h00;
  localparam logic [7:0] SEL_SETMASK = 8'h01;
  localparam logic [7:0] SEL_CLRMASK = 8'h02;
  localparam logic [7:0] SEL_WEDGE   = 8'h03;
  localparam logic [7:0] SEL_PEND    = 8'h10;
  localparam logic [7:0] SEL_MASK    = 8'h20;

  localparam logic [1:0] PAGE_CMD   = 2'd0;
  localparam logic [1:0] PAGE_SENSE = 2'd1;
  localparam logic [1:0] PAGE_ROUTE = 2'd2;

  localparam int WEDGE_RAISE_BIT = 31;
  localparam int ROUTE_PIN_LSB   = 8;
  localparam int ROUTE_EN_BIT    = 15;

  typedef struct packed {
    logic          setMask;
    logic          clrMask;
    logic          raise;
    logic          ack;
    logic          senseWe;
    logic          routeWe;
    logic [7:0]    idx;
    logic [DW-1:0] data;
  } strobe_t;
endpackage

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int PIN_W   = 3
) (
  input  logic                       regWe,
  input  logic [AW-1:0]              regAddr,
  input  logic [DW-1:0]              regWdata,
  input  logic [NUM_SRC-1:0]         pendVec,
  input  logic [NUM_SRC-1:0]         maskVec,
  input  logic [NUM_SRC*3-1:0]       senseFlat,
  input  logic [NUM_SRC*NUM_CPU-1:0] cpuFlat,
  input  logic [NUM_SRC*PIN_W-1:0]   pinFlat,
  input  logic [NUM_SRC-1:0]         mapEnVec,
  output strobe_t                    strb,
  output logic [DW-1:0]              regRdata
);
  localparam int NWORDS = (NUM_SRC + 31) / 32;
  localparam logic [4:0] CFG_N = 5'(NUM_SRC / 8 - 1);

  logic [1:0] page;
  logic [7:0] sel;
  logic       cmdPage;
  logic [NWORDS*32-1:0] pendPad;
  logic [NWORDS*32-1:0] maskPad;

  assign page    = regAddr[9:8];
  assign sel     = regAddr[7:0];
  assign cmdPage = (page == PAGE_CMD);

  // write decode into one-cycle strobes
  always_comb begin
    strb         = '0;
    strb.data    = regWdata;
    strb.idx     = cmdPage ? regWdata[7:0] : sel;
    strb.setMask = regWe && cmdPage && (sel == SEL_SETMASK);
    strb.clrMask = regWe && cmdPage && (sel == SEL_CLRMASK);
    strb.raise   = regWe && cmdPage && (sel == SEL_WEDGE) &&  regWdata[WEDGE_RAISE_BIT];
    strb.ack     = regWe && cmdPage && (sel == SEL_WEDGE) && !regWdata[WEDGE_RAISE_BIT];
    strb.senseWe = regWe && (page == PAGE_SENSE);
    strb.routeWe = regWe && (page == PAGE_ROUTE);
  end

  always_comb begin
    pendPad = '0;
    maskPad = '0;
    pendPad[NUM_SRC-1:0] = pendVec;
    maskPad[NUM_SRC-1:0] = maskVec;
  end

  // combinational read mux
  always_comb begin
    regRdata = '0;
    unique case (page)
      PAGE_CMD: begin
        if (sel == SEL_CONFIG) begin
          regRdata[4:0] = CFG_N;
        end else if (sel >= SEL_PEND && int'(sel - SEL_PEND) < NWORDS) begin
          regRdata = pendPad[int'(sel - SEL_PEND)*32 +: 32];
        end else if (sel >= SEL_MASK && int'(sel - SEL_MASK) < NWORDS) begin
          regRdata = maskPad[int'(sel - SEL_MASK)*32 +: 32];
        end
      end
      PAGE_SENSE: begin
        if (int'(sel) < NUM_SRC) regRdata[2:0] = senseFlat[int'(sel)*3 +: 3];
      end
      PAGE_ROUTE: begin
        if (int'(sel) < NUM_SRC) begin
          regRdata[NUM_CPU-1:0]                = cpuFlat[int'(sel)*NUM_CPU +: NUM_CPU];
          regRdata[ROUTE_PIN_LSB +: PIN_W]     = pinFlat[int'(sel)*PIN_W +: PIN_W];
          regRdata[ROUTE_EN_BIT]               = mapEnVec[int'(sel)];
        end
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_PIN = 6,
  parameter int PIN_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strb,
  input  logic [NUM_SRC-1:0]         intIn,
  output logic [NUM_SRC-1:0]         pendVec,
  output logic [NUM_SRC-1:0]         maskVec,
  output logic [NUM_SRC-1:0]         trigVec,
  output logic [NUM_SRC*3-1:0]       senseFlat,
  output logic [NUM_SRC*NUM_CPU-1:0] cpuFlat,
  output logic [NUM_SRC*PIN_W-1:0]   pinFlat,
  output logic [NUM_SRC-1:0]         mapEnVec,
  output logic [NUM_CPU*NUM_PIN-1:0] irqPins
);
  localparam int NOUT = NUM_CPU * NUM_PIN;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic               hit;
    logic               maskQ, polQ, trigQ, dualQ, prevQ, latchQ, mapEnQ;
    logic [NUM_CPU-1:0] cpuQ;
    logic [PIN_W-1:0]   pinQ;
    logic               rise, fall, edgeHit, lvl;

    assign hit     = (strb.idx == 8'(i));
    assign rise    =  intIn[i] & ~prevQ;
    assign fall    = ~intIn[i] &  prevQ;
    assign edgeHit = dualQ ? (rise | fall) : (polQ ? rise : fall);
    assign lvl     = polQ ? intIn[i] : ~intIn[i];

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        maskQ  <= 1'b0;
        polQ   <= 1'b1;
        trigQ  <= 1'b0;
        dualQ  <= 1'b0;
        prevQ  <= 1'b0;
        latchQ <= 1'b0;
        mapEnQ <= 1'b0;
        cpuQ   <= '0;
        pinQ   <= '0;
      end else begin
        prevQ <= intIn[i];
        if (hit && strb.setMask)      maskQ <= 1'b1;
        else if (hit && strb.clrMask) maskQ <= 1'b0;
        if (hit && strb.senseWe) begin
          polQ  <= strb.data[0];
          trigQ <= strb.data[1];
          dualQ <= strb.data[2];
        end
        if (hit && strb.routeWe) begin
          cpuQ   <= strb.data[NUM_CPU-1:0];
          pinQ   <= strb.data[ROUTE_PIN_LSB +: PIN_W];
          mapEnQ <= strb.data[ROUTE_EN_BIT];
        end
        // edge latch: new edges and raises win over an acknowledge
        if (!trigQ)                           latchQ <= 1'b0;
        else if (edgeHit || (hit && strb.raise)) latchQ <= 1'b1;
        else if (hit && strb.ack)             latchQ <= 1'b0;
      end
    end

    assign pendVec[i]                      = trigQ ? latchQ : lvl;
    assign maskVec[i]                      = maskQ;
    assign trigVec[i]                      = trigQ;
    assign senseFlat[i*3 +: 3]             = {dualQ, trigQ, polQ};
    assign cpuFlat[i*NUM_CPU +: NUM_CPU]   = cpuQ;
    assign pinFlat[i*PIN_W +: PIN_W]       = pinQ;
    assign mapEnVec[i]                     = mapEnQ;
  end

  // route active lines onto processor pins
  logic [NUM_SRC-1:0] liveVec;
  logic [NOUT-1:0]    pinNext;

  assign liveVec = pendVec & maskVec & mapEnVec;

  always_comb begin
    pinNext = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int p = 0; p < NUM_PIN; p++) begin
          if (liveVec[s] && cpuFlat[s*NUM_CPU + c] &&
              (pinFlat[s*PIN_W +: PIN_W] == PIN_W'(p)))
            pinNext[c*NUM_PIN + p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) irqPins <= '0;
    else     irqPins <= pinNext;
  end
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_PIN = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         intIn,
  input  logic                       regWe,
  input  logic [AW-1:0]              regAddr,
  input  logic [DW-1:0]              regWdata,
  output logic [DW-1:0]              regRdata,
  output logic [NUM_CPU*NUM_PIN-1:0] irqPins
);
  localparam int PIN_W = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

  strobe_t                    strb;
  logic [NUM_SRC-1:0]         pendVec, maskVec, trigVec, mapEnVec;
  logic [NUM_SRC*3-1:0]       senseFlat;
  logic [NUM_SRC*NUM_CPU-1:0] cpuFlat;
  logic [NUM_SRC*PIN_W-1:0]   pinFlat;

  sic_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PIN_W(PIN_W)) uCtrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .pendVec(pendVec), .maskVec(maskVec), .senseFlat(senseFlat),
    .cpuFlat(cpuFlat), .pinFlat(pinFlat), .mapEnVec(mapEnVec),
    .strb(strb), .regRdata(regRdata)
  );

  sic_datapath #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN), .PIN_W(PIN_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .intIn(intIn),
    .pendVec(pendVec), .maskVec(maskVec), .trigVec(trigVec),
    .senseFlat(senseFlat), .cpuFlat(cpuFlat), .pinFlat(pinFlat),
    .mapEnVec(mapEnVec), .irqPins(irqPins)
  );
endmodule

// File: rtl/shared_irq_ctrl_chk.sv
module shared_irq_ctrl_chk
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_PIN = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       regWe,
  input logic [AW-1:0]              regAddr,
  input logic [DW-1:0]              regWdata,
  input logic [NUM_SRC-1:0]         maskVec,
  input logic [NUM_SRC-1:0]         pendVec,
  input logic [NUM_SRC-1:0]         trigVec,
  input logic [NUM_CPU*NUM_PIN-1:0] irqPins
);
  logic [7:0] wIdx;
  logic       idxOk, isCmd;
  assign wIdx  = regWdata[7:0];
  assign idxOk = int'(wIdx) < NUM_SRC;
  assign isCmd = regWe && (regAddr[9:8] == PAGE_CMD);

  assert_pins_low_after_reset_R2: assert property (@(posedge clk)
    $past(rst) |-> (irqPins == '0));

  assert_setmask_enables_R3: assert property (@(posedge clk) disable iff (rst)
    (isCmd && regAddr[7:0] == SEL_SETMASK && idxOk) |=> maskVec[$past(wIdx)]);

  assert_clrmask_disables_R4: assert property (@(posedge clk) disable iff (rst)
    (isCmd && regAddr[7:0] == SEL_CLRMASK && idxOk) |=> !maskVec[$past(wIdx)]);

  assert_raise_sets_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (isCmd && regAddr[7:0] == SEL_WEDGE && regWdata[WEDGE_RAISE_BIT] && idxOk && trigVec[wIdx])
    |=> pendVec[$past(wIdx)]);

  assert_pin_needs_live_source_R9: assert property (@(posedge clk) disable iff (rst)
    (|irqPins) |-> $past(|(maskVec & pendVec)));
endmodule

bind shared_irq_ctrl shared_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN)) uChk (
  .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .maskVec(maskVec), .pendVec(pendVec), .trigVec(trigVec), .irqPins(irqPins)
);

// File: tb/tb_shared_irq_ctrl.sv
module tb_shared_irq_ctrl;
  localparam int NUM_SRC = 32;
  localparam int NUM_CPU = 4;
  localparam int NUM_PIN = 6;
  localparam int NOUT    = NUM_CPU * NUM_PIN;

  localparam logic [9:0] A_CFG   = 10'h000;
  localparam logic [9:0] A_SET   = 10'h001;
  localparam logic [9:0] A_CLR   = 10'h002;
  localparam logic [9:0] A_WEDGE = 10'h003;
  localparam logic [9:0] A_PEND  = 10'h010;
  localparam logic [9:0] A_MASK  = 10'h020;

  // {sense[2:0], firstIn, secondIn, expectedPending}
  localparam logic [5:0] VEC [12] = '{
    6'b001_0_1_1, 6'b001_1_0_0,   // level active high
    6'b000_0_0_1, 6'b000_0_1_0,   // level active low
    6'b011_0_1_1, 6'b011_1_0_0,   // rising edge
    6'b010_1_0_1, 6'b010_0_1_0,   // falling edge
    6'b110_0_1_1, 6'b110_1_0_1,   // both edges, polarity low
    6'b111_1_0_1, 6'b111_0_0_0    // both edges, polarity high
  };

  logic            clk = 0;
  logic            rst = 1;
  logic [NUM_SRC-1:0] intIn = '0;
  logic            regWe = 0;
  logic [9:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NOUT-1:0] irqPins;

  int nChecks = 0;
  int nErr = 0;
  logic [31:0] rv;

  shared_irq_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PIN(NUM_PIN)) dut (
    .clk(clk), .rst(rst), .intIn(intIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqPins(irqPins)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(2);

    // reset state
    rd(A_CFG, rv);          chk("R1 config field", rv, 32'd3);
    rd(A_MASK, rv);         chk("R2 masks after reset", rv, 32'h0);
    rd(A_PEND, rv);         chk("R2 pending after reset", rv, 32'h0);
    rd(10'h100, rv);        chk("R2 sense of line 0", rv, 32'h1);
    rd(10'h21f, rv);        chk("R2 route of line 31", rv, 32'h0);
    chk("R2 pins after reset", 32'(irqPins), 32'h0);

    // mask commands
    wr(A_SET, 32'd3);
    rd(A_MASK, rv);         chk("R3 set mask 3", rv, 32'h8);
    wr(A_SET, 32'd7);
    wr(A_CLR, 32'd3);
    rd(A_MASK, rv);         chk("R4 clear mask 3 keeps 7", rv, 32'h80);
    wr(A_SET, 32'd40);
    rd(A_MASK, rv);         chk("R11 set mask index 40 ignored", rv, 32'h80);
    wr(A_CLR, 32'd7);
    rd(A_MASK, rv);         chk("R10 mask word reads empty", rv, 32'h0);

    // sense table on line 5
    for (int k = 0; k < 12; k++) begin
      logic [5:0] v;
      string tag;
      v = VEC[k];
      tag = !v[4] ? "R5" : (v[5] ? "R7" : "R6");
      wr(10'h105, {29'd0, v[5:3]});
      intIn[5] = v[2];
      idle(2);
      wr(A_WEDGE, 32'd5);
      intIn[5] = v[1];
      idle(2);
      rd(A_PEND, rv);
      chk($sformatf("%s sense %b in %b->%b", tag, v[5:3], v[2], v[1]), 32'(rv[5]), 32'(v[0]));
      intIn[5] = 1'b0;
      idle(2);
    end

    // level line survives acknowledge
    wr(10'h105, 32'h0);
    idle(1);
    wr(A_WEDGE, 32'd5);
    rd(A_PEND, rv);         chk("R5 ack leaves level line pending", 32'(rv[5]), 32'h1);
    wr(10'h105, 32'h1);

    // edge latch holds after input returns
    wr(10'h106, 32'h3);
    intIn[6] = 1'b1; idle(2);
    intIn[6] = 1'b0; idle(2);
    rd(A_PEND, rv);         chk("R6 rising edge held after input drops", 32'(rv[6]), 32'h1);
    wr(A_WEDGE, 32'd6);
    rd(A_PEND, rv);         chk("R8 ack clears latched edge", 32'(rv[6]), 32'h0);

    // software raise and routing
    wr(10'h109, 32'h3);
    wr(10'h209, 32'h0000_8404);
    rd(10'h209, rv);        chk("R9 route readback", rv, 32'h0000_8404);
    wr(A_SET, 32'd9);
    wr(A_WEDGE, 32'h8000_0009);
    rd(A_PEND, rv);         chk("R8 raise sets pending", rv, 32'h200);
    idle(2);
    chk("R9 pin cpu2 pin4", 32'(irqPins), 32'h1 << (2*NUM_PIN + 4));
    wr(A_WEDGE, 32'd9);
    idle(2);
    chk("R9 pin low after ack", 32'(irqPins), 32'h0);
    wr(A_WEDGE, 32'h8000_0028);
    rd(A_PEND, rv);         chk("R11 raise index 40 ignored", rv, 32'h0);

    wr(10'h209, 32'h0000_0404);
    wr(A_WEDGE, 32'h8000_0009);
    idle(2);
    chk("R9 pin low with mapping off", 32'(irqPins), 32'h0);
    wr(10'h209, 32'h0000_8404);
    idle(2);
    chk("R9 pin high once mapping on", 32'(irqPins), 32'h1 << (2*NUM_PIN + 4));
    wr(A_CLR, 32'd9);
    idle(2);
    chk("R9 pin low once masked", 32'(irqPins), 32'h0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule